// File: doc/BRIEF.md
# Next Program Counter Unit

This block holds the program counter of a small 32-bit load/store processor and chooses the address of the next instruction on every enabled clock edge. It receives the instruction word currently being executed, a flag from the register file or comparator telling whether the two source operands are equal, and the value of the first source register. From these it selects one of four destinations:
- the following word
- a branch target relative to the following word
- an absolute target within the current 256 MiB region
- an address held in a register

The unit also presents the return address for the two linking jumps. It names the register that must receive it and raises a write strobe for that register. Fetch memory and the register file sit outside the block. The surrounding pipeline uses the enable input to freeze the counter during stalls.

A jump through a register whose value is not word-aligned is refused. The block raises a misalignment flag, keeps the counter where it is and does not write the link register. The outside trap logic is then responsible for redirecting the flow.

Top module: `npc_unit`

## Requirements
- R1: While `rst_ni` is low, `pc_o` equals the parameter `RESET_VEC`, and it keeps that value until the first enabled clock edge after release.
- R2: When `en_i` is low, `pc_o` keeps its value across the clock edge, and both `link_we_o` and `misalign_o` are low.
- R3: An instruction that is neither a branch nor a jump (opcode in bits 31:26 other than 2, 3, 4, 5, and not opcode 0 with function code 8 or 9 in bits 5:0) advances `pc_o` by 4.
- R4: Opcode 4 (branch on equal) with `rs_eq_rt_i` high loads `pc_o + 4 + (sign-extended bits 15:0 shifted left by 2)`. With `rs_eq_rt_i` low, the counter advances by 4.
- R5: Opcode 5 (branch on not equal) takes the branch target of R4 when `rs_eq_rt_i` is low. When `rs_eq_rt_i` is high, the counter advances by 4.
- R6: Opcode 2 (jump) and opcode 3 (jump and link) load `{pc_o[31:28], instr_i[25:0], 2'b00}`.
- R7: Opcode 0 with function code 8 (jump register) or 9 (jump register and link) loads `rs_val_i` when its two low bits are zero.
- R8: For function code 8 or 9 with `rs_val_i[1:0]` non-zero and `en_i` high, `misalign_o` is high in that cycle. `pc_o` is unchanged after the edge and `link_we_o` is low. `misalign_o` is low for every other instruction.
- R9: `link_o` always equals `pc_o + 4`. `link_we_o` is high exactly for an enabled opcode 3 and for an enabled, aligned function code 9. `link_reg_o` is then `LINK_REG` (31) for opcode 3 and `instr_i[15:11]` for function code 9.
- R10: `pc_o[1:0]` stays zero at all times when `RESET_VEC` is word-aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Advance enable; low freezes the counter |
| instr_i | input | 32 | Instruction word being executed |
| rs_eq_rt_i | input | 1 | High when the two source operands are equal |
| rs_val_i | input | ADDR_W | Value of the first source register |
| pc_o | output | ADDR_W | Current program counter |
| link_o | output | ADDR_W | Return address, counter plus 4 |
| link_we_o | output | 1 | Write strobe for the link register |
| link_reg_o | output | 5 | Index of the register receiving `link_o` |
| misalign_o | output | 1 | Register jump target not word-aligned |

## Verification
The bench builds the unit with `RESET_VEC` set to 32'hBFC0_0000. Because the upper four bits of that value are non-zero, an absolute jump that failed to keep the region bits of the current counter would land in a visibly wrong region. The counter also starts far from zero, so the backward branches are exercised, and a branch with offset -1 lands back on its own address. `LINK_REG` and `ADDR_W` keep their defaults, so the link index check compares against 31 and the full 32-bit splice is covered.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam logic [5:0] OP_SPECIAL = 6'h00;
  localparam logic [5:0] OP_JMP     = 6'h02;
  localparam logic [5:0] OP_JMPL    = 6'h03;
  localparam logic [5:0] OP_BREQ    = 6'h04;
  localparam logic [5:0] OP_BRNE    = 6'h05;
  localparam logic [5:0] FN_JREG    = 6'h08;
  localparam logic [5:0] FN_JREGL   = 6'h09;

  typedef enum logic [2:0] {
    FLOW_SEQ, FLOW_BREQ, FLOW_BRNE, FLOW_JMP, FLOW_JMPL, FLOW_JREG, FLOW_JREGL
  } flow_e;

  typedef struct packed {
    flow_e       flow;
    logic [4:0]  rd;
    logic [15:0] off;
    logic [25:0] idx;
  } dec_t;
endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
(
  input  logic [31:0] instr_i,
  output dec_t        dec_o
);
  logic [5:0] op, fn;
  assign op = instr_i[31:26];
  assign fn = instr_i[5:0];

  always_comb begin
    dec_o.flow = FLOW_SEQ;
    unique case (op)
      OP_JMP:  dec_o.flow = FLOW_JMP;
      OP_JMPL: dec_o.flow = FLOW_JMPL;
      OP_BREQ: dec_o.flow = FLOW_BREQ;
      OP_BRNE: dec_o.flow = FLOW_BRNE;
      OP_SPECIAL: begin
        if (fn == FN_JREG)       dec_o.flow = FLOW_JREG;
        else if (fn == FN_JREGL) dec_o.flow = FLOW_JREGL;
      end
      default: dec_o.flow = FLOW_SEQ;
    endcase
    dec_o.rd  = instr_i[15:11];
    dec_o.off = instr_i[15:0];
    dec_o.idx = instr_i[25:0];
  end
endmodule

// File: rtl/npc_target.sv
module npc_target #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [15:0]       off_i,
  input  logic [25:0]       idx_i,
  output logic [ADDR_W-1:0] seq_o,
  output logic [ADDR_W-1:0] br_o,
  output logic [ADDR_W-1:0] jmp_o
);
  localparam int SEXT_W   = ADDR_W - 18;
  localparam int REGION_W = ADDR_W - 28;

  logic [ADDR_W-1:0] off_ext;

  assign seq_o   = pc_i + ADDR_W'(4);
  assign off_ext = {{SEXT_W{off_i[15]}}, off_i, 2'b00};
  // branch base is the following word
  assign br_o    = seq_o + off_ext;

  generate
    if (REGION_W > 0) begin : g_region
      assign jmp_o = {pc_i[ADDR_W-1 -: REGION_W], idx_i, 2'b00};
    end else begin : g_flat
      assign jmp_o = ADDR_W'({idx_i, 2'b00});
    end
  endgenerate
endmodule

// File: rtl/npc_select.sv
module npc_select
  import npc_pkg::*;
#(
  parameter int         ADDR_W   = 32,
  parameter logic [4:0] LINK_REG = 5'd31
) (
  input  logic              en_i,
  input  dec_t              dec_i,
  input  logic              eq_i,
  input  logic [ADDR_W-1:0] rs_val_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] seq_i,
  input  logic [ADDR_W-1:0] br_i,
  input  logic [ADDR_W-1:0] jmp_i,
  output logic [ADDR_W-1:0] next_o,
  output logic              link_we_o,
  output logic [4:0]        link_reg_o,
  output logic              misalign_o
);
  logic reg_jump, bad_tgt;

  assign reg_jump = (dec_i.flow == FLOW_JREG) || (dec_i.flow == FLOW_JREGL);
  assign bad_tgt  = |rs_val_i[1:0];

  always_comb begin
    next_o     = seq_i;
    link_we_o  = 1'b0;
    misalign_o = 1'b0;
    link_reg_o = (dec_i.flow == FLOW_JREGL) ? dec_i.rd : LINK_REG;
    if (!en_i) begin
      next_o = pc_i;
    end else begin
      unique case (dec_i.flow)
        FLOW_BREQ: next_o = eq_i  ? br_i : seq_i;
        FLOW_BRNE: next_o = !eq_i ? br_i : seq_i;
        FLOW_JMP:  next_o = jmp_i;
        FLOW_JMPL: begin
          next_o    = jmp_i;
          link_we_o = 1'b1;
        end
        FLOW_JREG, FLOW_JREGL: begin
          if (bad_tgt) begin
            next_o     = pc_i;
            misalign_o = 1'b1;
          end else begin
            next_o    = rs_val_i;
            link_we_o = (dec_i.flow == FLOW_JREGL);
          end
        end
        default: next_o = seq_i;
      endcase
    end
    if (!reg_jump) misalign_o = 1'b0;
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] RESET_VEC = '0,
  parameter logic [4:0]        LINK_REG  = 5'd31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [31:0]       instr_i,
  input  logic              rs_eq_rt_i,
  input  logic [ADDR_W-1:0] rs_val_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] link_o,
  output logic              link_we_o,
  output logic [4:0]        link_reg_o,
  output logic              misalign_o
);
  dec_t              dec;
  logic [ADDR_W-1:0] pc_q, next_pc, seq_pc, br_pc, jmp_pc;

  npc_decode u_dec (
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  npc_target #(.ADDR_W(ADDR_W)) u_tgt (
    .pc_i  (pc_q),
    .off_i (dec.off),
    .idx_i (dec.idx),
    .seq_o (seq_pc),
    .br_o  (br_pc),
    .jmp_o (jmp_pc)
  );

  npc_select #(.ADDR_W(ADDR_W), .LINK_REG(LINK_REG)) u_sel (
    .en_i       (en_i),
    .dec_i      (dec),
    .eq_i       (rs_eq_rt_i),
    .rs_val_i   (rs_val_i),
    .pc_i       (pc_q),
    .seq_i      (seq_pc),
    .br_i       (br_pc),
    .jmp_i      (jmp_pc),
    .next_o     (next_pc),
    .link_we_o  (link_we_o),
    .link_reg_o (link_reg_o),
    .misalign_o (misalign_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= RESET_VEC;
    else         pc_q <= next_pc;
  end

  assign pc_o   = pc_q;
  assign link_o = seq_pc;
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic [31:0]       instr_i,
  input logic [ADDR_W-1:0] pc_o,
  input logic [ADDR_W-1:0] link_o,
  input logic              link_we_o,
  input logic              misalign_o
);
  logic is_abs;
  assign is_abs = (instr_i[31:26] == 6'h02) || (instr_i[31:26] == 6'h03);

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> pc_o == $past(pc_o));

  a_r2_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !link_we_o && !misalign_o);

  a_r8_misalign_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |=> pc_o == $past(pc_o));

  a_r8_no_link: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |-> !link_we_o);

  a_r6_region: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && is_abs |=> pc_o[ADDR_W-1 -: 4] == $past(pc_o[ADDR_W-1 -: 4]));

  a_r9_link_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_we_o |=> pc_o != $past(link_o) || $past(instr_i[31:26]) != 6'h03
                  || $past(instr_i[25:0]) == $past(link_o[27:2]));

  a_r10_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_o[1:0] == 2'b00);
endmodule

bind npc_unit npc_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .instr_i    (instr_i),
  .pc_o       (pc_o),
  .link_o     (link_o),
  .link_we_o  (link_we_o),
  .misalign_o (misalign_o)
);

// File: tb/npc_unit_bench.sv
module npc_unit_bench;
  localparam logic [31:0] RVEC = 32'hBFC0_0000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic        rs_eq_rt_i = 1'b0;
  logic [31:0] rs_val_i = '0;
  logic [31:0] pc_o, link_o;
  logic        link_we_o, misalign_o;
  logic [4:0]  link_reg_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] pc_m;

  npc_unit #(.ADDR_W(32), .RESET_VEC(RVEC), .LINK_REG(5'd31)) u_npc_unit (
    .clk_i, .rst_ni, .en_i, .instr_i, .rs_eq_rt_i, .rs_val_i,
    .pc_o, .link_o, .link_we_o, .link_reg_o, .misalign_o
  );

  always #10 clk_i = ~clk_i;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_i(input logic [5:0] op, input logic [15:0] imm);
    return {op, 5'd3, 5'd4, imm};
  endfunction
  function automatic logic [31:0] mk_j(input logic [5:0] op, input logic [25:0] idx);
    return {op, idx};
  endfunction
  function automatic logic [31:0] mk_r(input logic [4:0] rd, input logic [5:0] fn);
    return {6'h00, 5'd7, 5'd0, rd, 5'd0, fn};
  endfunction

  // expected behaviour from the requirements
  task automatic model(input logic [31:0] pc, input logic [31:0] ins, input logic eq,
                       input logic [31:0] rs, input logic en,
                       output logic [31:0] npc, output logic mis, output logic lwe,
                       output logic [4:0] lreg);
    logic [5:0] op, fn;
    logic [31:0] seq, br;
    op = ins[31:26]; fn = ins[5:0];
    seq = pc + 32'd4;
    br  = seq + {{14{ins[15]}}, ins[15:0], 2'b00};
    npc = seq; mis = 1'b0; lwe = 1'b0; lreg = 5'd31;
    if (!en) npc = pc;
    else if (op == 6'h04) npc = eq ? br : seq;
    else if (op == 6'h05) npc = eq ? seq : br;
    else if (op == 6'h02 || op == 6'h03) begin
      npc = {pc[31:28], ins[25:0], 2'b00};
      lwe = (op == 6'h03);
    end else if (op == 6'h00 && (fn == 6'h08 || fn == 6'h09)) begin
      if (fn == 6'h09) lreg = ins[15:11];
      if (rs[1:0] != 2'b00) begin
        npc = pc; mis = 1'b1;
      end else begin
        npc = rs; lwe = (fn == 6'h09);
      end
    end
  endtask

  task automatic step(input logic en, input logic [31:0] ins, input logic eq,
                      input logic [31:0] rs, input string req);
    logic [31:0] npc; logic mis, lwe; logic [4:0] lreg;
    @(negedge clk_i);
    en_i = en; instr_i = ins; rs_eq_rt_i = eq; rs_val_i = rs;
    #2;
    model(pc_m, ins, eq, rs, en, npc, mis, lwe, lreg);
    check(misalign_o == mis, "R8 misalign", 32'(misalign_o), 32'(mis));
    check(link_we_o == lwe, "R9 link_we", 32'(link_we_o), 32'(lwe));
    check(link_o == pc_m + 32'd4, "R9 link", link_o, pc_m + 32'd4);
    if (lwe) check(link_reg_o == lreg, "R9 link_reg", 32'(link_reg_o), 32'(lreg));
    @(posedge clk_i); #2;
    check(pc_o == npc, req, pc_o, npc);
    check(pc_o[1:0] == 2'b00, "R10 aligned", pc_o, {pc_o[31:2], 2'b00});
    pc_m = npc;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    #25;
    check(pc_o == RVEC, "R1 reset", pc_o, RVEC);
    @(negedge clk_i); rst_ni = 1'b1;
    pc_m = RVEC;
    #2;
    check(pc_o == RVEC, "R1 after release", pc_o, RVEC);

    step(1'b0, mk_j(6'h03, 26'h155), 1'b0, 32'h0, "R2 hold");
    step(1'b1, 32'h0000_0020, 1'b0, 32'h0, "R3 sequential");
    step(1'b1, mk_i(6'h04, 16'hFFFF), 1'b1, 32'h0, "R4 beq self");
    step(1'b1, mk_i(6'h04, 16'h0010), 1'b0, 32'h0, "R4 beq not taken");
    step(1'b1, mk_i(6'h05, 16'h8000), 1'b0, 32'h0, "R5 bne far back");
    step(1'b1, mk_i(6'h05, 16'h7FFF), 1'b1, 32'h0, "R5 bne not taken");
    step(1'b1, mk_j(6'h02, 26'h3FF_FFFF), 1'b0, 32'h0, "R6 j region");
    step(1'b1, mk_j(6'h03, 26'h000_0100), 1'b0, 32'h0, "R6 jal");
    step(1'b1, mk_r(5'd9, 6'h09), 1'b0, 32'h1234_0002, "R8 jalr misaligned");
    step(1'b1, mk_r(5'd0, 6'h08), 1'b0, 32'h4000_0001, "R8 jr misaligned");
    step(1'b1, mk_r(5'd0, 6'h08), 1'b0, 32'h0040_0080, "R7 jr");
    step(1'b1, mk_r(5'd12, 6'h09), 1'b0, 32'hBFC0_1000, "R7 jalr");
    step(1'b0, mk_r(5'd1, 6'h09), 1'b0, 32'h0000_0003, "R2 hold misaligned");

    for (int i = 0; i < 600; i++) begin
      int unsigned cls;
      logic [31:0] ins, rs;
      logic en, eq;
      string req;
      cls = $urandom_range(0, 6);
      en  = ($urandom_range(0, 7) != 0);
      eq  = $urandom_range(0, 1) == 1;
      rs  = $urandom;
      if ($urandom_range(0, 3) != 0) rs[1:0] = 2'b00;
      case (cls)
        0: begin ins = mk_i(6'h04, 16'($urandom)); req = "R4 rand"; end
        1: begin ins = mk_i(6'h05, 16'($urandom)); req = "R5 rand"; end
        2: begin ins = mk_j(6'h02, 26'($urandom)); req = "R6 rand"; end
        3: begin ins = mk_j(6'h03, 26'($urandom)); req = "R6 rand jal"; end
        4: begin ins = mk_r(5'($urandom), 6'h08); req = "R7 rand jr"; end
        5: begin ins = mk_r(5'($urandom), 6'h09); req = "R7 rand jalr"; end
        default: begin
          ins = $urandom;
          if (ins[31:26] inside {6'h00, 6'h02, 6'h03, 6'h04, 6'h05}) ins[31:26] = 6'h23;
          req = "R3 rand";
        end
      endcase
      if (!en) req = "R2 rand hold";
      step(en, ins, eq, rs, req);
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule